// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block turns a slow oscillator tick into a one-cycle strobe once per second. A qualified tick is one where the tick input and the oscillator enable are both high. Each qualified tick advances a sub-second counter. When that counter reaches the programmed limit, the next qualified tick wraps it to zero and raises the seconds strobe for one clock cycle.

The limit comes from a 21-bit calibration word. The low 16 bits give the whole tick count. Bits 19:16 give a fractional count in sixteenths of a tick. Bit 20 turns the fractional correction on.

A 4-bit phase counter steps once per second and runs through sixteen values. In the seconds whose phase is below the fractional value, one extra tick is added. Over any sixteen consecutive seconds the average period therefore grows by that many sixteenths of a tick.

The calibration word is sampled only at a seconds boundary, so a second never changes length partway through. The sub-second count is available on a port for readback. The block has no streaming data path: every port is a plain level or a pulse, so there is no valid/ready handshake and no back-pressure.

Top module: `rtc_sec_prescaler`

## Requirements
- R1: While reset is held, and immediately after it is released, `sec_strobe` is 0 and `subsec_count` is 0. The active calibration after reset is whole count 0x7FFF with the fraction disabled, so the first second lasts 32768 qualified ticks.
- R2: With the fraction disabled, a second lasts (W+1) qualified ticks, where W is `cal_word[15:0]`. On the wrapping tick, `subsec_count` returns to 0. W = 0 gives a strobe on every qualified tick.
- R3: `sec_strobe` is high for exactly the one clock cycle after the wrapping qualified tick, and it is never high unless the previous cycle had a qualified tick.
- R4: `subsec_count` equals the number of qualified ticks since the last seconds boundary.
- R5: When `cal_word[20]` = 1, let F be `cal_word[19:16]`. A phase counter starts at 0 after reset and increments, modulo 16, at every boundary. A second whose phase is below F lasts W+2 ticks instead of W+1. Any 16 consecutive seconds therefore total 16·(W+1)+F ticks.
- R6: When `cal_word[20]` = 0, the field in bits 19:16 has no effect on any period.
- R7: A change on `cal_word` takes effect from the second that begins at the next boundary. The second in progress keeps the length it started with.
- R8: A cycle with `osc_en` low or `osc_tick` low leaves `subsec_count` unchanged and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | Oscillator enable that qualifies the tick |
| osc_tick | input | 1 | One-cycle tick from the slow oscillator |
| cal_word | input | 21 | Calibration: [15:0] whole count, [19:16] fraction, [20] fraction enable |
| sec_strobe | output | 1 | One-cycle pulse at each seconds boundary |
| subsec_count | output | 16 | Qualified ticks counted in the current second |

## Verification
The bench changes the calibration in the middle of a long second. A design that loads the word immediately would cut that second short instead of finishing the full 32768 ticks.

It sums sixteen consecutive periods with fractions of 5 and 15 enabled, and with a fraction set but disabled. A design with the phase compare or the enable wrong would be off by a few ticks over that window.

A whole count of zero checks that the counter still wraps on every tick, rather than running through 65536 ticks. Gated and held enables check that a tick during disable neither moves the readback nor shifts the strobe.

// File: rtl/rtcpre_pkg.sv
package rtcpre_pkg;
  localparam int WHOLE_W = 16;
  localparam int FRAC_W  = 4;
  localparam int CAL_W   = WHOLE_W + FRAC_W + 1;
  localparam int CNT_W   = WHOLE_W + 1;

  typedef struct packed {
    logic              fen;
    logic [FRAC_W-1:0] frac;
    logic [WHOLE_W-1:0] whole;
  } trim_t;

  function automatic trim_t unpack_trim(input logic [CAL_W-1:0] w);
    trim_t t;
    t.whole = w[WHOLE_W-1:0];
    t.frac  = w[WHOLE_W+FRAC_W-1:WHOLE_W];
    t.fen   = w[CAL_W-1];
    return t;
  endfunction
endpackage

// File: rtl/rtcpre_trim_reg.sv
module rtcpre_trim_reg
  import rtcpre_pkg::*;
#(
  parameter logic [CAL_W-1:0] RESET_CAL = CAL_W'(16'h7FFF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CAL_W-1:0] cal_word,
  output trim_t            act
);
  // Active trim only changes at a seconds boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act <= unpack_trim(RESET_CAL);
    else if (load) act <= unpack_trim(cal_word);
  end
endmodule

// File: rtl/rtcpre_phase.sv
module rtcpre_phase
  import rtcpre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              fen,
  input  logic [FRAC_W-1:0] frac,
  output logic [FRAC_W-1:0] phase,
  output logic              stretch
);
  generate
    if (FRAC_W > 0) begin : g_frac
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       phase <= '0;
        else if (advance) phase <= phase + 1'b1;
      end
      // The first F phases of each 16-second cycle take the extra tick.
      assign stretch = fen && (phase < frac);
    end else begin : g_nofrac
      assign phase   = '0;
      assign stretch = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rtcpre_div.sv
module rtcpre_div
  import rtcpre_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_q,
  input  logic [WHOLE_W-1:0] whole,
  input  logic               stretch,
  output logic               wrap,
  output logic               strobe,
  output logic [WHOLE_W-1:0] count_out
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit     = {1'b0, whole} + {{(CNT_W-1){1'b0}}, stretch};
  assign wrap      = tick_q && (cnt == limit);
  assign count_out = cnt[WHOLE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= wrap;
      if (tick_q) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler
  import rtcpre_pkg::*;
#(
  parameter logic [CAL_W-1:0] RESET_CAL = CAL_W'(16'h7FFF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_en,
  input  logic               osc_tick,
  input  logic [CAL_W-1:0]   cal_word,
  output logic               sec_strobe,
  output logic [WHOLE_W-1:0] subsec_count
);
  logic              tick_q;
  logic              wrap;
  logic              stretch;
  logic [FRAC_W-1:0] phase;
  trim_t             act_trim;

  assign tick_q = osc_en & osc_tick;

  rtcpre_trim_reg #(.RESET_CAL(RESET_CAL)) i_trim (
    .clk(clk), .rst_n(rst_n), .load(wrap), .cal_word(cal_word), .act(act_trim)
  );

  rtcpre_phase i_phase (
    .clk(clk), .rst_n(rst_n), .advance(wrap),
    .fen(act_trim.fen), .frac(act_trim.frac),
    .phase(phase), .stretch(stretch)
  );

  rtcpre_div i_div (
    .clk(clk), .rst_n(rst_n), .tick_q(tick_q), .whole(act_trim.whole),
    .stretch(stretch), .wrap(wrap), .strobe(sec_strobe), .count_out(subsec_count)
  );
endmodule

// File: rtl/rtcpre_chk.sv
module rtcpre_chk
  import rtcpre_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               osc_en,
  input logic               osc_tick,
  input logic               sec_strobe,
  input logic [WHOLE_W-1:0] subsec_count,
  input trim_t              act_trim,
  input logic [FRAC_W-1:0]  phase,
  input logic               stretch
);
  // R3
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> $past(osc_en && osc_tick));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_en && osc_tick) |=> ($stable(subsec_count) && !sec_strobe));

  // R2
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> (subsec_count == '0));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && osc_tick) |=> (sec_strobe || (subsec_count == $past(subsec_count) + 1'b1)));

  // R7
  trim_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_strobe |-> $stable(act_trim));

  // R5
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> (phase == $past(phase) + 1'b1));

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_strobe |-> $stable(phase));

  // R6
  frac_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_trim.fen |-> !stretch);
endmodule

bind rtc_sec_prescaler rtcpre_chk i_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .osc_tick(osc_tick),
  .sec_strobe(sec_strobe), .subsec_count(subsec_count),
  .act_trim(act_trim), .phase(phase), .stretch(stretch)
);

// File: tb/test_rtc_sec_prescaler.sv
module test_rtc_sec_prescaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_en = 1'b0;
  logic        osc_tick = 1'b0;
  logic [20:0] cal_in = 21'h007FFF;
  logic        sec_strobe;
  logic [15:0] subsec_count;

  int checks = 0;
  int errors = 0;
  int sec_idx = 0;
  logic [20:0] act_model = 21'h007FFF;

  always #10 clk = ~clk;

  rtc_sec_prescaler i_rtc_sec_prescaler (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .osc_tick(osc_tick),
    .cal_word(cal_in), .sec_strobe(sec_strobe), .subsec_count(subsec_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_period();
    int p;
    p = int'(act_model[15:0]) + 1;
    if (act_model[20] && ((sec_idx % 16) < int'(act_model[19:16]))) p = p + 1;
    return p;
  endfunction

  // mode 0: steady ticks; 1: tick every third cycle; 2: enable dropped for ten cycles;
  // 3: steady ticks with readback report
  task automatic measure(input int mode, input string req, input int mid_at,
                         input logic [20:0] mid_cal, output int got);
    int n = 0;
    int s = 0;
    int exp;
    bit rb_ok = 1'b1;
    logic q;
    exp = exp_period();
    while (1) begin
      case (mode)
        1: begin osc_en = 1'b1; osc_tick = ((s % 3) == 0); end
        2: begin osc_tick = 1'b1; osc_en = !(s >= 2 && s < 12); end
        default: begin osc_en = 1'b1; osc_tick = 1'b1; end
      endcase
      if (s == mid_at) cal_in = mid_cal;
      q = osc_en & osc_tick;
      @(posedge clk);
      if (q) n++;
      @(negedge clk);
      s++;
      if (sec_strobe) break;
      if (subsec_count != n[15:0]) rb_ok = 1'b0;
    end
    check(n == exp, req, n, exp);
    if (mode == 2) check(rb_ok, "R8 count held while disabled", int'(rb_ok), 1);
    if (mode == 1) check(rb_ok, "R8 idle ticks ignored", int'(rb_ok), 1);
    if (mode == 3) begin
      check(rb_ok, "R4 readback tracks ticks", int'(rb_ok), 1);
      check(subsec_count == 16'd0, "R2 restart at zero", int'(subsec_count), 0);
    end
    sec_idx++;
    act_model = cal_in;
    got = n;
  endtask

  task automatic t_reset();
    check(sec_strobe == 1'b0, "R1 strobe in reset", int'(sec_strobe), 0);
    check(subsec_count == 16'd0, "R1 count in reset", int'(subsec_count), 0);
    rst_n = 1'b1;
    check(sec_strobe == 1'b0 && subsec_count == 16'd0, "R1 after release",
          int'(subsec_count), 0);
  endtask

  task automatic t_default_and_midchange();
    int g;
    // R1 default second; R7 calibration changed partway through it
    measure(0, "R1 R7 default second", 100, 21'h000009, g);
    check(g == 32768, "R7 second not cut short", g, 32768);
    measure(0, "R2 whole count 9", -1, '0, g);
  endtask

  task automatic t_whole();
    int g;
    cal_in = 21'h000004;
    measure(0, "R7 old length kept", -1, '0, g);
    measure(0, "R2 whole count 4", -1, '0, g);
    measure(0, "R2 whole count 4 again", -1, '0, g);
    cal_in = 21'h000000;
    measure(0, "R7 old length kept", -1, '0, g);
    measure(0, "R2 whole count 0", -1, '0, g);
    measure(0, "R3 strobe every tick", -1, '0, g);
  endtask

  task automatic t_readback();
    int g;
    cal_in = 21'h000006;
    measure(0, "R7 transition", -1, '0, g);
    measure(3, "R4 period 7", -1, '0, g);
  endtask

  task automatic t_gating();
    int g;
    measure(1, "R8 sparse ticks", -1, '0, g);
    measure(2, "R8 enable low hold", -1, '0, g);
  endtask

  task automatic t_frac(input bit en, input int f, input string req);
    int g;
    int sum = 0;
    cal_in = {en, 4'(f), 16'd3};
    measure(0, "R7 transition", -1, '0, g);
    for (int k = 0; k < 16; k++) begin
      measure(0, req, -1, '0, g);
      sum += g;
    end
    check(sum == 64 + (en ? f : 0), req, sum, 64 + (en ? f : 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_default_and_midchange();
    t_whole();
    t_readback();
    t_gating();
    t_frac(1'b1, 5, "R5 fraction 5");
    t_frac(1'b0, 7, "R6 fraction disabled");
    t_frac(1'b1, 15, "R5 fraction 15");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule